// File: doc/BRIEF.md
# Slow-Clock Waveform Output Selector

This block drives a single real-time-clock output pin. A 3-bit source selector picks what the pin shows. The choices are a constant low level, one of four fixed 50% square waves, a signal derived from the alarm flag, or a pulse train. The pulse train's high time and period each come from their own small code field. The configuration fields and the alarm flag level arrive as plain inputs. Register decoding lives elsewhere.

The block runs on the system clock. All time-based behaviour advances on a one-cycle tick-enable strobe supplied at 65536 Hz, which is twice the 32768 Hz slow clock. A single free-running 16-bit tick counter clears at reset and advances by one on every strobe. Every square wave and the pulse train are decoded from this counter, so all waveforms keep a fixed phase relation. The pin is driven from a register. The value shown after a clock edge reflects the counter value and the inputs sampled at that edge.

Top module: `rtc_wave_out`

## Requirements
- R1: While rst_ni is low, wave_o is 0 and the tick counter is 0. All waveform phases are measured from that counter value.
- R2: With src_sel_i = 0, wave_o is 0 after the next clock edge.
- R3: Selector codes 1, 2, 3 and 4 give square waves of 1 Hz, 32 Hz, 64 Hz and 512 Hz. Each output equals bit 15, 10, 9 or 6 of the tick counter, in that order.
- R4: The tick counter advances by exactly one on each clock edge where tick_en_i is 1. It holds on every other edge, and wraps from 65535 to 0.
- R5: With src_sel_i = 5 held unchanged, the internal toggle state inverts on every clock edge where alarm_i is 1 and was 0 at the previous edge. wave_o shows that toggle state.
- R6: Any change of src_sel_i between two clock edges clears the toggle state to 0 at the later edge.
- R7: With src_sel_i = 6, wave_o after an edge equals alarm_i as sampled at that edge.
- R8: With src_sel_i = 7, hi_code_i values 0 to 7 set the pulse high time to 2048, 1024, 256, 64, 32, 8, 2 and 1 ticks.
- R9: With src_sel_i = 7, per_code_i values 0 to 3 set the pulse period to 65536, 32768, 16384 and 8192 ticks.
- R10: A pulse starts at tick counter phase 0 of each period. It is high while the phase (the counter modulo the period) is below the high time, and low for the rest of the period.
- R11: wave_o changes only at clock edges. After each edge it equals the selected source evaluated on the updated counter and on the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | One-cycle strobe at 65536 Hz |
| src_sel_i | input | 3 | Output source selector |
| hi_code_i | input | 3 | Pulse high-time code |
| per_code_i | input | 2 | Pulse period code |
| alarm_i | input | 1 | Alarm flag level |
| wave_o | output | 1 | Registered output pin value |

## Verification
Assertions check on every cycle that the counter holds or steps by one as the strobe dictates. They also check that a selector change clears the toggle state and that an alarm rising edge in toggle mode inverts it. Two output modes are checked the same way: the off code forces the pin low, and copy mode follows the alarm. The exact square-wave bit choices, the pulse duty and period for each code, and the alignment of pulses to phase zero need long runs against the bench's own tick model. Only the scenarios show these, including wrap-around of the 1 Hz wave and a full 65536-tick period.

// File: rtl/rtc_wave_pkg.sv
package rtc_wave_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_SQ_1HZ   = 3'd1,
    SRC_SQ_32HZ  = 3'd2,
    SRC_SQ_64HZ  = 3'd3,
    SRC_SQ_512HZ = 3'd4,
    SRC_ALM_TGL  = 3'd5,
    SRC_ALM_COPY = 3'd6,
    SRC_PULSE    = 3'd7
  } src_e;

  localparam int unsigned NUM_SQ = 4;

  // log2 of square-wave frequency in Hz, indexed by selector code minus one
  function automatic int unsigned sq_freq_log2(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 5;
      2:       return 6;
      default: return 9;
    endcase
  endfunction

  // log2 of pulse high time in ticks
  function automatic logic [3:0] hi_log2(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd11;
      3'd1:    return 4'd10;
      3'd2:    return 4'd8;
      3'd3:    return 4'd6;
      3'd4:    return 4'd5;
      3'd5:    return 4'd3;
      3'd6:    return 4'd1;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_wave_tick_cnt.sv
module rtc_wave_tick_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = tick_en_i ? cnt_q + 1'b1 : cnt_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> $stable(cnt_q)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/rtc_wave_square.sv
module rtc_wave_square
  import rtc_wave_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [NUM_SQ-1:0] sq_o
);

  // counter spans one 1 Hz period at twice the slow clock
  for (genvar g = 0; g < NUM_SQ; g++) begin : g_sq
    localparam int unsigned BIT_IDX = CNT_W - 1 - sq_freq_log2(g);
    assign sq_o[g] = cnt_i[BIT_IDX];
  end

endmodule

// File: rtl/rtc_wave_pulse.sv
module rtc_wave_pulse
  import rtc_wave_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       hi_code_i,
  input  logic [1:0]       per_code_i,
  output logic             pulse_o
);

  localparam int unsigned LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] per_mask;
  logic [CNT_W-1:0] phase;
  logic [LIM_W-1:0] hi_lim;

  assign per_mask = {CNT_W{1'b1}} >> per_code_i;
  assign phase    = cnt_i & per_mask;
  assign hi_lim   = LIM_W'(1) << hi_log2(hi_code_i);
  assign pulse_o  = {1'b0, phase} < hi_lim;

endmodule

// File: rtl/rtc_wave_alarm.sv
module rtc_wave_alarm
  import rtc_wave_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] src_sel_i,
  input  logic       alarm_i,
  output logic       tgl_next_o
);

  logic [2:0] sel_q;
  logic       alm_q;
  logic       tgl_q;
  logic       sel_chg;
  logic       alm_rise;

  assign sel_chg  = src_sel_i != sel_q;
  assign alm_rise = alarm_i & ~alm_q;

  always_comb begin
    tgl_next_o = tgl_q;
    if (sel_chg)                                      tgl_next_o = 1'b0;
    else if (src_sel_i == SRC_ALM_TGL && alm_rise)    tgl_next_o = ~tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SRC_OFF;
      alm_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      sel_q <= src_sel_i;
      alm_q <= alarm_i;
      tgl_q <= tgl_next_o;
    end
  end

  AST_TGL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != sel_q) |=> !tgl_q); // R6
  AST_TGL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_ALM_TGL && src_sel_i == sel_q && alarm_i && !alm_q)
      |=> tgl_q != $past(tgl_q)); // R5

endmodule

// File: rtl/rtc_wave_out.sv
module rtc_wave_out
  import rtc_wave_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic [2:0] src_sel_i,
  input  logic [2:0] hi_code_i,
  input  logic [1:0] per_code_i,
  input  logic       alarm_i,
  output logic       wave_o
);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_next;
  logic [NUM_SQ-1:0] sq;
  logic              pulse;
  logic              tgl_next;
  logic              wave_d;
  logic              wave_q;

  rtc_wave_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  // decode from the next count so the pin register lines up with the counter
  rtc_wave_square #(.CNT_W(CNT_W)) u_sq (
    .cnt_i (cnt_next),
    .sq_o  (sq)
  );

  rtc_wave_pulse #(.CNT_W(CNT_W)) u_pulse (
    .cnt_i      (cnt_next),
    .hi_code_i  (hi_code_i),
    .per_code_i (per_code_i),
    .pulse_o    (pulse)
  );

  rtc_wave_alarm u_alm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_sel_i  (src_sel_i),
    .alarm_i    (alarm_i),
    .tgl_next_o (tgl_next)
  );

  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_OFF:      wave_d = 1'b0;
      SRC_SQ_1HZ:   wave_d = sq[0];
      SRC_SQ_32HZ:  wave_d = sq[1];
      SRC_SQ_64HZ:  wave_d = sq[2];
      SRC_SQ_512HZ: wave_d = sq[3];
      SRC_ALM_TGL:  wave_d = tgl_next;
      SRC_ALM_COPY: wave_d = alarm_i;
      SRC_PULSE:    wave_d = pulse;
      default:      wave_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign wave_o = wave_q;

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_OFF) |=> !wave_o); // R2
  AST_ALM_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_ALM_COPY) |=> wave_o == $past(alarm_i)); // R7
  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> !wave_o); // R1

endmodule

// File: tb/rtc_wave_out_test.sv
module rtc_wave_out_test;

  typedef struct packed {
    logic [2:0]  sel;
    logic [2:0]  hc;
    logic [1:0]  pc;
    logic        half;
    int unsigned cycles;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 3'd0, 2'd0, 1'b1, 600},
    '{3'd1, 3'd0, 2'd0, 1'b0, 33000},
    '{3'd2, 3'd0, 2'd0, 1'b1, 3000},
    '{3'd3, 3'd0, 2'd0, 1'b0, 3000},
    '{3'd0, 3'd0, 2'd0, 1'b0, 300},
    '{3'd7, 3'd0, 2'd3, 1'b0, 9000},
    '{3'd7, 3'd7, 2'd3, 1'b0, 9000},
    '{3'd7, 3'd6, 2'd3, 1'b1, 2000},
    '{3'd7, 3'd5, 2'd2, 1'b0, 17000},
    '{3'd7, 3'd1, 2'd1, 1'b0, 16500},
    '{3'd7, 3'd3, 2'd2, 1'b0, 1000},
    '{3'd7, 3'd2, 2'd0, 1'b0, 66000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [2:0] hc = 3'd0;
  logic [1:0] pc = 2'd0;
  logic       alarm = 1'b0;
  logic       wave;

  int n_run = 0;
  int n_fail = 0;
  int n_cyc = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt;
  logic        m_tgl;
  logic        m_alm_prev;
  logic [2:0]  m_sel_prev;

  always #10 clk = ~clk;

  rtc_wave_out uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_en_i  (tick_en),
    .src_sel_i  (sel),
    .hi_code_i  (hc),
    .per_code_i (pc),
    .alarm_i    (alarm),
    .wave_o     (wave)
  );

  function automatic int hi_ticks(input logic [2:0] c);
    case (c)
      3'd0: return 2048; 3'd1: return 1024; 3'd2: return 256; 3'd3: return 64;
      3'd4: return 32;   3'd5: return 8;    3'd6: return 2;   default: return 1;
    endcase
  endfunction

  function automatic int per_ticks(input logic [1:0] c);
    case (c)
      2'd0: return 65536; 2'd1: return 32768; 2'd2: return 16384; default: return 8192;
    endcase
  endfunction

  function automatic logic expect_wave();
    int ph;
    case (sel)
      3'd0: return 1'b0;
      3'd1: return m_cnt[15];
      3'd2: return m_cnt[10];
      3'd3: return m_cnt[9];
      3'd4: return m_cnt[6];
      3'd5: return m_tgl;
      3'd6: return alarm;
      default: begin
        ph = int'(m_cnt) % per_ticks(pc);
        return ph < hi_ticks(hc);
      end
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wave_o=%0b expected %0b (sel=%0d cnt=%0d)", req, act, exp, sel, m_cnt);
    end
  endtask

  // one clock: inputs already set, update model at the edge, compare at negedge
  task automatic cyc(input logic tk, input string req);
    tick_en = tk;
    @(posedge clk);
    #1;
    if (tk) m_cnt = m_cnt + 16'd1;
    if (sel != m_sel_prev) m_tgl = 1'b0;
    else if (sel == 3'd5 && alarm && !m_alm_prev) m_tgl = ~m_tgl;
    m_alm_prev = alarm;
    m_sel_prev = sel;
    @(negedge clk);
    check(req, wave, expect_wave());
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    m_cnt = '0; m_tgl = 1'b0; m_alm_prev = 1'b0; m_sel_prev = 3'd0;
    repeat (3) @(negedge clk);
    check("R1", wave, 1'b0);
    sel = 3'd4;
    repeat (2) @(negedge clk);
    check("R1", wave, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R8 R9 R10 R11: table walk against tick model
    for (int v = 0; v < NV; v++) begin
      sel = VECS[v].sel;
      hc  = VECS[v].hc;
      pc  = VECS[v].pc;
      for (int i = 0; i < int'(VECS[v].cycles); i++)
        cyc(VECS[v].half ? logic'(i[0]) : 1'b1, sel == 3'd7 ? "R8/R9/R10" : "R3/R4");
    end

    // R2: off holds low while ticking through a 512 Hz edge region
    sel = 3'd0;
    for (int i = 0; i < 200; i++) cyc(1'b1, "R2");

    // R7: alarm copy follows level with no tick
    sel = 3'd6;
    cyc(1'b0, "R7");
    alarm = 1'b1; cyc(1'b0, "R7");
    alarm = 1'b0; cyc(1'b0, "R7");
    alarm = 1'b1; cyc(1'b1, "R7");

    // R6: enter toggle mode with alarm already high, no rise seen
    sel = 3'd5;
    cyc(1'b0, "R6");
    cyc(1'b0, "R6");
    // R5: rises toggle, level and falls do not
    for (int k = 0; k < 5; k++) begin
      alarm = 1'b0; cyc(1'b0, "R5");
      alarm = 1'b1; cyc(1'b1, "R5");
      cyc(1'b0, "R5");
    end
    // R6: leave and re-enter clears toggle state
    alarm = 1'b0; cyc(1'b0, "R5");
    alarm = 1'b1; cyc(1'b0, "R5");
    sel = 3'd6; cyc(1'b0, "R6");
    sel = 3'd5; cyc(1'b0, "R6");
    alarm = 1'b0; cyc(1'b0, "R6");
    // R6: change coinciding with a rise clears instead of toggling
    sel = 3'd0; cyc(1'b0, "R6");
    sel = 3'd5; alarm = 1'b1; cyc(1'b0, "R6");
    alarm = 1'b0; cyc(1'b0, "R6");
    alarm = 1'b1; cyc(1'b0, "R5");

    // R4: no ticks leave pulse level frozen
    sel = 3'd7; hc = 3'd7; pc = 2'd3;
    for (int i = 0; i < 50; i++) cyc(1'b0, "R4");

    // R1: reset mid-run clears counter and output
    sel = 3'd4;
    tick_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", wave, 1'b0);
    m_cnt = '0; m_tgl = 1'b0; m_alm_prev = 1'b0; m_sel_prev = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) cyc(1'b1, "R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule